// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a sixteen-bank on-chip scratchpad and takes one request that carries up to sixteen lane addresses at once. Each lane holds a 32-bit word address. The low four address bits pick the bank, and the remaining bits pick the row inside that bank. A bank can serve one row per clock. Lanes that land in different banks are served together. Lanes that share a bank but want different rows are spread over successive cycles. Lanes that want exactly the same word share a single access.

A request is offered with a per-lane enable mask, the addresses, a write flag and per-lane write data. It is taken when `req_ready` is high. `req_ready` then stays low while replay cycles remain. When every enabled lane has been served, `rsp_done` pulses for one clock. In that same clock, `rsp_data` holds each lane's word and `rsp_cycles` reports how many bank cycles the request used. For a write request, each lane's data is stored at its address. When enabled lanes collide on one word, the lowest-numbered of those lanes supplies the stored value.

Top module: `sps_conflict_serializer`

## Requirements
- R1: The bank of a lane is address bits [3:0], and the row inside the bank is the remaining upper address bits. A word written at an address is returned by a later read of that address, including addresses that wrap past the top of the array.
- R2: When all enabled lanes fall in distinct banks, the request completes in one cycle (`rsp_cycles` = 1).
- R3: Enabled lanes that carry the identical address share one bank access and add no cycle. When all sixteen lanes carry the same address, the request takes one cycle.
- R4: `rsp_cycles` equals the largest number of distinct addresses that enabled lanes map to any single bank. For example, a lane stride of 2 gives 2, a stride of 4 gives 4, a stride of 8 gives 8, a stride of 16 gives 16, and any odd stride gives 1.
- R5: `req_ready` falls in the clock after acceptance and stays low until the request finishes. `rsp_done` is a one-clock pulse that appears max(`rsp_cycles`,1) rising edges after the accepting edge, with `req_ready` high again in that clock.
- R6: Disabled lanes are excluded from the cycle count, and their `rsp_data` slot keeps its previous value.
- R7: On a write request, each bank cycle stores the write data of the lowest-numbered pending lane at that bank's selected row. Every enabled lane of a write returns the word's contents from before the write.
- R8: A request with an all-zero mask is accepted and completes after one clock with `rsp_cycles` = 0.
- R9: After reset, `req_ready` is 1, `rsp_done` is 0, `rsp_cycles` is 0 and every `rsp_data` slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | 16 | Per-lane enable, bit n for lane n |
| req_addr | input | 160 | Lane n word address in bits [10n+9:10n] |
| req_wdata | input | 512 | Lane n write data in bits [32n+31:32n] |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_cycles | output | 5 | Bank cycles used by the last request |
| rsp_data | output | 512 | Lane n read data in bits [32n+31:32n] |

## Verification
The bench walks lane strides of 0, 1, 2, 3, 4, 5, 8 and 16, and two scattered patterns whose cycle counts it computes itself.

- A design that counted lanes per bank rather than distinct addresses would report 16 cycles for the all-same-address broadcast.
- A design that ignored the mask would inflate the count for sparse masks and overwrite the data slots of disabled lanes.
- The empty mask must finish with zero cycles and must not hang.
- A write in which twelve lanes collide on one word must store the lowest enabled lane's data. A priority turned the wrong way stores lane 15's data, and the read-back shows it.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sps_state_e;
endpackage

// File: rtl/sps_bank_arbiter.sv
// Per-bank selection: each bank takes the lowest-numbered pending lane as
// leader and serves its row. Every pending lane whose bank and row match the
// leader's is marked served in the same cycle (broadcast).
module sps_bank_arbiter #(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int AW    = 10
) (
  input  logic [LANES-1:0]                 pending,
  input  logic [LANES*AW-1:0]              addr,
  output logic [BANKS-1:0]                 bank_act,
  output logic [BANKS*(AW-$clog2(BANKS))-1:0] bank_row,
  output logic [BANKS*$clog2(LANES)-1:0]   bank_lead,
  output logic [LANES-1:0]                 served
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = AW - BANK_W;
  localparam int LANE_W = $clog2(LANES);

  logic [ROW_W-1:0]  row_v  [BANKS];
  logic [LANE_W-1:0] lead_v [BANKS];

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_act[b] = 1'b0;
      row_v[b]    = '0;
      lead_v[b]   = '0;
      // Descending scan so the lowest lane is the last to overwrite.
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && (addr[l*AW +: BANK_W] == BANK_W'(b))) begin
          bank_act[b] = 1'b1;
          row_v[b]    = addr[l*AW+BANK_W +: ROW_W];
          lead_v[b]   = LANE_W'(l);
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = pending[l] && bank_act[addr[l*AW +: BANK_W]] &&
                  (addr[l*AW+BANK_W +: ROW_W] == row_v[addr[l*AW +: BANK_W]]);
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_flat
    assign bank_row[b*ROW_W +: ROW_W]    = row_v[b];
    assign bank_lead[b*LANE_W +: LANE_W] = lead_v[b];
  end
endmodule

// File: rtl/sps_bank_store.sv
// One storage array per bank, written on the clock and read combinationally.
module sps_bank_store #(
  parameter int BANKS = 16,
  parameter int ROW_W = 6,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic [BANKS-1:0]       wr_en,
  input  logic [BANKS*ROW_W-1:0] row,
  input  logic [BANKS*DW-1:0]    wdata,
  output logic [BANKS*DW-1:0]    rdata
);
  localparam int DEPTH = 1 << ROW_W;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[b]) begin
        mem[row[b*ROW_W +: ROW_W]] <= wdata[b*DW +: DW];
      end
    end

    assign rdata[b*DW +: DW] = mem[row[b*ROW_W +: ROW_W]];
  end
endmodule

// File: rtl/sps_conflict_serializer.sv
module sps_conflict_serializer
  import sps_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_we,
  input  logic [LANES-1:0]              req_mask,
  input  logic [LANES*AW-1:0]           req_addr,
  input  logic [LANES*DW-1:0]           req_wdata,
  output logic                          rsp_done,
  output logic [$clog2(LANES+1)-1:0]    rsp_cycles,
  output logic [LANES*DW-1:0]           rsp_data
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = AW - BANK_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES + 1);

  sps_state_e                state_q, state_d;
  logic [LANES-1:0]          pend_q, pend_d;
  logic [CNT_W-1:0]          cyc_q, cyc_d;
  logic                      done_q, done_d;
  logic [LANES*DW-1:0]       data_q, data_d;
  logic [LANES*AW-1:0]       addr_q;
  logic [LANES*DW-1:0]       wdata_q;
  logic                      we_q;
  logic                      accept;

  logic [BANKS-1:0]          bank_act;
  logic [BANKS*ROW_W-1:0]    bank_row;
  logic [BANKS*LANE_W-1:0]   bank_lead;
  logic [LANES-1:0]          served;
  logic [BANKS-1:0]          bank_wr;
  logic [BANKS*DW-1:0]       bank_wdata;
  logic [BANKS*DW-1:0]       bank_rdata;

  assign accept     = req_valid && (state_q == ST_IDLE);
  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_done   = done_q;
  assign rsp_cycles = cyc_q;
  assign rsp_data   = data_q;

  sps_bank_arbiter #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) i_arb (
    .pending  (pend_q),
    .addr     (addr_q),
    .bank_act (bank_act),
    .bank_row (bank_row),
    .bank_lead(bank_lead),
    .served   (served)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_wr
    assign bank_wr[b] = (state_q == ST_BUSY) && we_q && bank_act[b];
    assign bank_wdata[b*DW +: DW] =
      wdata_q[bank_lead[b*LANE_W +: LANE_W]*DW +: DW];
  end

  sps_bank_store #(.BANKS(BANKS), .ROW_W(ROW_W), .DW(DW)) i_store (
    .clk  (clk),
    .wr_en(bank_wr),
    .row  (bank_row),
    .wdata(bank_wdata),
    .rdata(bank_rdata)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cyc_d   = cyc_q;
    done_d  = 1'b0;
    data_d  = data_q;
    if (accept) begin
      state_d = ST_BUSY;
      pend_d  = req_mask;
      cyc_d   = '0;
    end else if (state_q == ST_BUSY) begin
      pend_d = pend_q & ~served;
      if (|served) begin
        cyc_d = cyc_q + 1'b1;
      end
      for (int l = 0; l < LANES; l++) begin
        if (served[l]) begin
          data_d[l*DW +: DW] = bank_rdata[addr_q[l*AW +: BANK_W]*DW +: DW];
        end
      end
      if (pend_d == '0) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  // Control and response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cyc_q   <= '0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cyc_q   <= cyc_d;
      done_q  <= done_d;
      data_q  <= data_d;
    end
  end

  // Request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_we;
    end
  end

  // R5: ready drops after acceptance, done is a single pulse with ready back
  p_accept_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_with_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
  // R4: every replay cycle retires at least one pending lane, count bounded
  p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && (|pend_q)) |=> ($countones(pend_q) < $countones($past(pend_q))));
  p_cycles_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_cycles <= CNT_W'(LANES)));
  // R8: empty mask finishes after one clock with zero cycles
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mask == '0)) |-> ##2 (rsp_done && (rsp_cycles == '0)));
endmodule

// File: tb/test_sps_conflict_serializer.sv
module test_sps_conflict_serializer;
  localparam int L  = 16;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NW = 1 << AW;
  localparam int NV = 12;

  // Vector table: base address, lane stride, mask, expected bank cycles
  localparam int unsigned V_BASE  [NV] = '{0, 5, 0, 7, 3, 100, 1, 0, 9, 0, 11, 1020};
  localparam int unsigned V_STRIDE[NV] = '{1, 2, 8, 3, 16, 0, 4, 8, 16, 1, 5, 1};
  localparam int unsigned V_MASK  [NV] = '{'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF,
                                           'hFFFF, 'h0005, 'h8001, 'h0000, 'hAAAA, 'hFFFF};
  localparam int          V_EXP   [NV] = '{1, 2, 8, 1, 16, 1, 4, 2, 2, 0, 1, 1};

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_we;
  logic            req_ready, rsp_done;
  logic [L-1:0]    req_mask;
  logic [L*AW-1:0] req_addr;
  logic [L*DW-1:0] req_wdata;
  logic [4:0]      rsp_cycles;
  logic [L*DW-1:0] rsp_data;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] mdl    [NW];
  logic [AW-1:0] t_addr [L];
  logic [DW-1:0] t_wd   [L];
  logic [DW-1:0] last_d [L];

  always #4 clk = ~clk;

  sps_conflict_serializer i_sps_conflict_serializer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_cycles(rsp_cycles), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Independent count: most distinct addresses landing in one bank
  function automatic int model_cycles(input logic [L-1:0] m);
    int worst = 0;
    for (int b = 0; b < 16; b++) begin
      int n = 0;
      for (int l = 0; l < L; l++) begin
        bit dup = 0;
        if (!m[l] || (int'(t_addr[l]) % 16) != b) continue;
        for (int j = 0; j < l; j++)
          if (m[j] && t_addr[j] == t_addr[l]) dup = 1;
        if (!dup) n++;
      end
      if (n > worst) worst = n;
    end
    return worst;
  endfunction

  task automatic run_req(input logic we, input logic [L-1:0] m, input int exp, input string tag);
    logic [DW-1:0] exp_d [L];
    int lat;
    bit ready_ok;
    for (int l = 0; l < L; l++) exp_d[l] = m[l] ? mdl[t_addr[l]] : last_d[l];
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_mask  = m;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW]  = t_addr[l];
      req_wdata[l*DW +: DW] = t_wd[l];
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    ready_ok = 1;
    while (!rsp_done && lat < 100) begin
      if (req_ready) ready_ok = 0;
      @(negedge clk);
      lat++;
    end
    chk(rsp_cycles == 5'(exp), {tag, " cycle count"}, rsp_cycles, exp);
    chk(lat == ((exp < 1) ? 1 : exp), "R5 done latency", lat, (exp < 1) ? 1 : exp);
    chk(ready_ok && req_ready, "R5 ready low while busy", req_ready, 1);
    begin
      bit ok = 1;
      bit hold_ok = 1;
      int bad = 0;
      for (int l = 0; l < L; l++) begin
        if (rsp_data[l*DW +: DW] != exp_d[l]) begin
          if (m[l]) ok = 0; else hold_ok = 0;
          bad = l;
        end
      end
      chk(ok, we ? "R7 write returns prior data" : "R1 read data",
          rsp_data[bad*DW +: DW], exp_d[bad]);
      if (m != '1) chk(hold_ok, "R6 inactive lane holds", rsp_data[bad*DW +: DW], exp_d[bad]);
    end
    @(negedge clk);
    chk(!rsp_done, "R5 done single pulse", rsp_done, 0);
    if (we) for (int l = L - 1; l >= 0; l--) if (m[l]) mdl[t_addr[l]] = t_wd[l];
    for (int l = 0; l < L; l++) last_d[l] = exp_d[l];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_mask = '0;
    req_addr = '0; req_wdata = '0;
    for (int l = 0; l < L; l++) begin last_d[l] = '0; t_wd[l] = '0; end
    for (int a = 0; a < NW; a++) mdl[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    chk(rsp_done == 1'b0, "R9 reset done", rsp_done, 0);
    chk(rsp_cycles == 5'd0, "R9 reset cycles", rsp_cycles, 0);
    chk(rsp_data == '0, "R9 reset data", rsp_data[31:0], 0);
    rst_n = 1'b1;

    // R1: fill the whole array with conflict-free writes
    for (int r = 0; r < NW / L; r++) begin
      for (int l = 0; l < L; l++) begin
        t_addr[l] = AW'(r * L + l);
        t_wd[l]   = (DW'(r * L + l) * 32'h9E3779B1) ^ 32'hA5A50000;
      end
      run_req(1'b1, '1, 1, "R2");
    end

    // Table-driven reads
    for (int v = 0; v < NV; v++) begin
      string tag;
      for (int l = 0; l < L; l++) t_addr[l] = AW'(V_BASE[v] + V_STRIDE[v] * l);
      if (V_MASK[v] == 0) tag = "R8";
      else if (V_STRIDE[v] == 0) tag = "R3";
      else if (V_EXP[v] == 1) tag = "R2";
      else tag = "R4";
      chk(model_cycles(L'(V_MASK[v])) == V_EXP[v], "R4 table self-consistency",
          model_cycles(L'(V_MASK[v])), V_EXP[v]);
      run_req(1'b0, L'(V_MASK[v]), V_EXP[v], tag);
    end

    // R4: scattered patterns, count from the bench model
    for (int l = 0; l < L; l++) t_addr[l] = AW'((l * 37 + (l % 3) * 16) % NW);
    run_req(1'b0, 16'hFFFF, model_cycles(16'hFFFF), "R4");
    for (int l = 0; l < L; l++) t_addr[l] = AW'(((l % 4) * 16 + (l / 4) * 64 + 3) % NW);
    run_req(1'b0, 16'h7FFE, model_cycles(16'h7FFE), "R4");

    // R7: colliding write, lowest enabled lane (lane 4) must win
    for (int l = 0; l < L; l++) begin
      t_addr[l] = AW'(200);
      t_wd[l]   = 32'hC0DE0000 + DW'(l);
    end
    run_req(1'b1, 16'hFFF0, 1, "R7");
    run_req(1'b0, 16'h0001, 1, "R3");
    chk(rsp_data[31:0] == 32'hC0DE0004, "R7 lowest lane wins", rsp_data[31:0], 32'hC0DE0004);

    // R8: empty mask between real requests
    run_req(1'b0, 16'h0000, 0, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule